// File: doc/BRIEF.md
# Two-Layer Overlay Pixel Compositor

This block merges two pixel-synchronous RGB888 video layers over a programmable solid background and emits one composited RGB pixel per clock. Each layer has an enable, a stacking priority, source and destination color keys, a layer-wide constant alpha and the option of using its own per-pixel alpha. A diagnostic mode replaces the composite with eight vertical color bars. The pixel streams arrive already aligned: one valid flag, one start-of-frame strobe and one start-of-line strobe are shared by both layers. The output keeps the input timing and lags it by a fixed three cycles.

All configuration inputs go into shadow registers on the clock edge where `in_sof` is high. Pixels accepted in that same cycle still use the previous shadow values, so software can change the configuration inputs at any time. A small mode machine selects the output source. `ST_IDLE` is the state after reset, before any frame start. The edge with `in_sof` high moves `ST_IDLE` to `ST_COMPOSE` when `cfg_bar_en` is low and to `ST_BARS` when it is high. A later `in_sof` edge moves `ST_COMPOSE` to `ST_BARS` when `cfg_bar_en` is high, and moves `ST_BARS` back to `ST_COMPOSE` when it is low. Without `in_sof` the state holds. In `ST_IDLE` the block composites with the reset shadow values: black background, both layers disabled.

Top module: `ovl_compositor`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` is 0 and `out_rgb` is 0.
- R2: `out_valid` equals the `in_valid` value presented three clock cycles earlier. The `out_rgb` value that goes with it is computed from that same earlier pixel.
- R3: Configuration inputs take effect only for pixels after an `in_sof` edge. Changes made without `in_sof`, including a bar request, leave the output unchanged.
- R4: When neither layer is enabled, every valid output pixel equals the shadowed background color. Pixels are packed R in bits 23:16, G in bits 15:8 and B in bits 7:0.
- R5: A layer is blended over the plane beneath it with alpha a, per channel, as (a*top + (255-a)*below + 127)/255 using integer division. a=255 yields the top pixel exactly and a=0 yields the plane beneath.
- R6: Alpha source per layer, set by `cfg_gmode`/`cfg_pmode`. Both off gives 255. Global only gives `cfg_galpha`. Per-pixel only gives `in_alpha`. Both on gives (galpha*pixel_alpha+127)/255.
- R7: The layer with the larger `cfg_zord` value is placed on top. On equal values layer 1 is on top of layer 0. A disabled layer contributes nothing.
- R8: With source keying on, a layer pixel equal to its `cfg_skey` is fully transparent.
- R9: With destination keying on, a layer pixel is fully transparent unless the plane directly beneath it matches its `cfg_dkey`. For the lower layer that plane is the background. For the upper layer it is the background with the lower layer already blended in.
- R10: In bar mode, output pixel column x goes to bar index min(7, x*8/`cfg_bar_width`). Bars 0 to 7 are white FFFFFF, yellow FFFF00, cyan 00FFFF, green 00FF00, magenta FF00FF, red FF0000, blue 0000FF and black 000000. The pixel that arrives with `in_sol` is column 0, and each valid pixel advances the column by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on both layers this cycle |
| in_sof | input | 1 | Frame start strobe; loads the shadow configuration |
| in_sol | input | 1 | Line start strobe; this pixel is column 0 |
| in_rgb | input | 2x24 | RGB888 pixel per layer, index = layer |
| in_alpha | input | 2x8 | Per-pixel alpha per layer |
| cfg_bg | input | 24 | Background color |
| cfg_en | input | 2 | Layer enables |
| cfg_zord | input | 2x2 | Stacking priority per layer |
| cfg_gmode | input | 2 | Use global alpha, per layer |
| cfg_pmode | input | 2 | Use per-pixel alpha, per layer |
| cfg_galpha | input | 2x8 | Global alpha per layer |
| cfg_sk_en | input | 2 | Source keying enable per layer |
| cfg_skey | input | 2x24 | Source key color per layer |
| cfg_dk_en | input | 2 | Destination keying enable per layer |
| cfg_dkey | input | 2x24 | Destination key color per layer |
| cfg_bar_en | input | 1 | Request color-bar mode |
| cfg_bar_width | input | 12 | Active line width for the bars |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composited RGB888 pixel |

## Verification
The assertions assume that reset lasts at least one clock with `in_valid` low. They also assume that a frame start is a cycle of its own, so the shadow registers and the mode state move only on `in_sof` edges. The stimulus follows this: every `in_sof` pulse is driven with `in_valid` low, and inputs change only on falling edges. The bar width is always at least eight, and the pixel palettes are chosen so that both the matching and the non-matching sides of each key comparison occur.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int CW   = 8;
    localparam int NCH  = 3;
    localparam int PW   = CW * NCH;
    localparam int AMAX = (1 << CW) - 1;
    localparam int NL   = 2;
    localparam int ZW   = 2;
    localparam int XW   = 12;
    localparam int NBAR = 8;

    typedef logic [PW-1:0] pix_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPOSE = 2'd1,
        ST_BARS    = 2'd2
    } mode_e;

    typedef struct packed {
        pix_t          rgb;
        logic [CW-1:0] a;
        logic          dk_en;
        pix_t          dkey;
    } layer_t;
endpackage

// File: rtl/ovl_mode_fsm.sv
module ovl_mode_fsm
    import ovl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sof,
    input  logic  bar_req,
    output mode_e mode,
    output logic  bars
);
    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (sof) state_d = bar_req ? ST_BARS : ST_COMPOSE;
            ST_COMPOSE: if (sof && bar_req) state_d = ST_BARS;
            ST_BARS:    if (sof && !bar_req) state_d = ST_COMPOSE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mode = state_q;
        bars = (state_q == ST_BARS);
    end
endmodule

// File: rtl/ovl_alpha_sel.sv
module ovl_alpha_sel
    import ovl_pkg::*;
(
    input  pix_t          rgb,
    input  logic [CW-1:0] pix_a,
    input  logic          en,
    input  logic          gmode,
    input  logic          pmode,
    input  logic [CW-1:0] galpha,
    input  logic          sk_en,
    input  pix_t          skey,
    output logic [CW-1:0] a_eff
);
    localparam int PRW = 2 * CW;
    logic [PRW-1:0] prod;

    always_comb begin
        prod = PRW'(galpha) * PRW'(pix_a) + PRW'(AMAX / 2);
        unique case ({gmode, pmode})
            2'b11:   a_eff = CW'(prod / PRW'(AMAX));
            2'b10:   a_eff = galpha;
            2'b01:   a_eff = pix_a;
            default: a_eff = CW'(AMAX);
        endcase
        if (!en || (sk_en && rgb == skey)) a_eff = '0;
    end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
    import ovl_pkg::*;
(
    input  pix_t          top,
    input  pix_t          bot,
    input  logic [CW-1:0] a,
    input  logic          dk_en,
    input  pix_t          dkey,
    output pix_t          res
);
    localparam int AW = 2 * CW + 1;
    localparam logic [CW-1:0] AM = CW'(AMAX);
    logic [CW-1:0] a_k;

    assign a_k = (dk_en && bot != dkey) ? '0 : a;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [AW-1:0] acc;
        always_comb begin
            acc = AW'(a_k) * AW'(top[c*CW +: CW])
                + AW'(AM - a_k) * AW'(bot[c*CW +: CW])
                + AW'(AMAX / 2);
            res[c*CW +: CW] = CW'(acc / AW'(AMAX));
        end
    end
endmodule

// File: rtl/ovl_bar_gen.sv
module ovl_bar_gen
    import ovl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sol,
    input  logic          valid,
    input  logic [XW-1:0] width,
    output pix_t          color
);
    localparam int IW = $clog2(NBAR);
    logic [XW-1:0]    col_q, col_cur;
    logic [XW+IW-1:0] scaled;
    logic [IW-1:0]    idx;

    assign col_cur = sol ? '0 : col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     col_q <= '0;
        else if (valid) col_q <= col_cur + 1'b1;
        else if (sol)   col_q <= '0;
    end

    always_comb begin
        scaled = {col_cur, {IW{1'b0}}};
        if (width == '0 || col_cur >= width) idx = IW'(NBAR - 1);
        else idx = IW'(scaled / (XW+IW)'(width));
        color = {{CW{~idx[1]}}, {CW{~idx[2]}}, {CW{~idx[0]}}};
    end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
    import ovl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic                   in_sol,
    input  logic [NL-1:0][PW-1:0]  in_rgb,
    input  logic [NL-1:0][CW-1:0]  in_alpha,
    input  logic [PW-1:0]          cfg_bg,
    input  logic [NL-1:0]          cfg_en,
    input  logic [NL-1:0][ZW-1:0]  cfg_zord,
    input  logic [NL-1:0]          cfg_gmode,
    input  logic [NL-1:0]          cfg_pmode,
    input  logic [NL-1:0][CW-1:0]  cfg_galpha,
    input  logic [NL-1:0]          cfg_sk_en,
    input  logic [NL-1:0][PW-1:0]  cfg_skey,
    input  logic [NL-1:0]          cfg_dk_en,
    input  logic [NL-1:0][PW-1:0]  cfg_dkey,
    input  logic                   cfg_bar_en,
    input  logic [XW-1:0]          cfg_bar_width,
    output logic                   out_valid,
    output logic [PW-1:0]          out_rgb
);
    // shadow configuration, loaded on frame start
    pix_t                  sh_bg;
    logic [NL-1:0]         sh_en, sh_gmode, sh_pmode, sh_sk_en, sh_dk_en;
    logic [NL-1:0][ZW-1:0] sh_zord;
    logic [NL-1:0][CW-1:0] sh_galpha;
    logic [NL-1:0][PW-1:0] sh_skey, sh_dkey;
    logic [XW-1:0]         sh_width;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_bg <= '0; sh_en <= '0; sh_gmode <= '0; sh_pmode <= '0;
            sh_sk_en <= '0; sh_dk_en <= '0; sh_zord <= '0; sh_galpha <= '0;
            sh_skey <= '0; sh_dkey <= '0; sh_width <= '0;
        end else if (in_sof) begin
            sh_bg <= cfg_bg; sh_en <= cfg_en; sh_gmode <= cfg_gmode;
            sh_pmode <= cfg_pmode; sh_sk_en <= cfg_sk_en; sh_dk_en <= cfg_dk_en;
            sh_zord <= cfg_zord; sh_galpha <= cfg_galpha; sh_skey <= cfg_skey;
            sh_dkey <= cfg_dkey; sh_width <= cfg_bar_width;
        end
    end

    mode_e mode;
    logic  bars;

    ovl_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sof(in_sof), .bar_req(cfg_bar_en),
        .mode(mode), .bars(bars)
    );

    logic [NL-1:0][CW-1:0] a_eff;
    for (genvar i = 0; i < NL; i++) begin : g_layer
        ovl_alpha_sel u_asel (
            .rgb(in_rgb[i]), .pix_a(in_alpha[i]), .en(sh_en[i]),
            .gmode(sh_gmode[i]), .pmode(sh_pmode[i]), .galpha(sh_galpha[i]),
            .sk_en(sh_sk_en[i]), .skey(sh_skey[i]), .a_eff(a_eff[i])
        );
    end

    pix_t bar_rgb;
    ovl_bar_gen u_bar (
        .clk(clk), .rst_n(rst_n), .sol(in_sol), .valid(in_valid),
        .width(sh_width), .color(bar_rgb)
    );

    // stacking: layer 1 wins ties
    logic   hi_i, lo_i;
    layer_t lay_hi, lay_lo;
    always_comb begin
        hi_i = (sh_zord[1] >= sh_zord[0]);
        lo_i = ~hi_i;
        lay_hi = '{rgb: in_rgb[hi_i], a: a_eff[hi_i], dk_en: sh_dk_en[hi_i], dkey: sh_dkey[hi_i]};
        lay_lo = '{rgb: in_rgb[lo_i], a: a_eff[lo_i], dk_en: sh_dk_en[lo_i], dkey: sh_dkey[lo_i]};
    end

    // stage 1
    logic   s1_valid, s1_bar;
    pix_t   s1_barc, s1_bg;
    layer_t s1_lo, s1_hi;
    // stage 2
    logic   s2_valid, s2_bar;
    pix_t   s2_barc, s2_mid;
    layer_t s2_hi;
    // stage 3
    logic   s3_bar;
    pix_t   mid_rgb, hi_rgb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0; s1_bar <= 1'b0; s1_barc <= '0; s1_bg <= '0;
            s1_lo <= '0; s1_hi <= '0;
        end else begin
            s1_valid <= in_valid; s1_bar <= bars; s1_barc <= bar_rgb;
            s1_bg <= sh_bg; s1_lo <= lay_lo; s1_hi <= lay_hi;
        end
    end

    ovl_blend u_blend_lo (
        .top(s1_lo.rgb), .bot(s1_bg), .a(s1_lo.a),
        .dk_en(s1_lo.dk_en), .dkey(s1_lo.dkey), .res(mid_rgb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0; s2_bar <= 1'b0; s2_barc <= '0; s2_mid <= '0; s2_hi <= '0;
        end else begin
            s2_valid <= s1_valid; s2_bar <= s1_bar; s2_barc <= s1_barc;
            s2_mid <= mid_rgb; s2_hi <= s1_hi;
        end
    end

    ovl_blend u_blend_hi (
        .top(s2_hi.rgb), .bot(s2_mid), .a(s2_hi.a),
        .dk_en(s2_hi.dk_en), .dkey(s2_hi.dkey), .res(hi_rgb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_rgb <= '0; s3_bar <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            out_rgb   <= s2_bar ? s2_barc : hi_rgb;
            s3_bar    <= s2_bar;
        end
    end
endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk
    import ovl_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_sof,
    input logic          in_valid,
    input logic          out_valid,
    input logic [PW-1:0] out_rgb,
    input logic [1:0]    mode,
    input logic [PW-1:0] sh_bg,
    input logic          s2_valid,
    input logic          s2_bar,
    input logic [CW-1:0] s2_hi_a,
    input logic          s2_hi_dk_en,
    input logic [PW-1:0] s2_hi_rgb,
    input logic [PW-1:0] s2_mid,
    input logic          s3_bar
);
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sof |=> $stable(mode)); // R3

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sof |=> $stable(sh_bg)); // R3

    AST_OPAQUE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && !s2_bar && s2_hi_a == CW'(AMAX) && !s2_hi_dk_en)
        |=> (out_rgb == $past(s2_hi_rgb))); // R5

    AST_CLEAR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && !s2_bar && s2_hi_a == '0) |=> (out_rgb == $past(s2_mid))); // R5

    AST_BAR_PALETTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && s3_bar) |->
        ((out_rgb[23:16] == 8'h00 || out_rgb[23:16] == 8'hFF) &&
         (out_rgb[15:8]  == 8'h00 || out_rgb[15:8]  == 8'hFF) &&
         (out_rgb[7:0]   == 8'h00 || out_rgb[7:0]   == 8'hFF))); // R10
endmodule

bind ovl_compositor ovl_compositor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_valid(in_valid),
    .out_valid(out_valid), .out_rgb(out_rgb), .mode(mode), .sh_bg(sh_bg),
    .s2_valid(s2_valid), .s2_bar(s2_bar), .s2_hi_a(s2_hi.a),
    .s2_hi_dk_en(s2_hi.dk_en), .s2_hi_rgb(s2_hi.rgb), .s2_mid(s2_mid),
    .s3_bar(s3_bar)
);

// File: tb/ovl_compositor_tb.sv
`timescale 1ns/1ps
module ovl_compositor_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic             in_valid, in_sof, in_sol;
    logic [1:0][23:0] in_rgb;
    logic [1:0][7:0]  in_alpha;
    logic [23:0]      c_bg;
    logic [1:0]       c_en, c_gm, c_pm, c_sk, c_dk;
    logic [1:0][1:0]  c_z;
    logic [1:0][7:0]  c_ga;
    logic [1:0][23:0] c_skey, c_dkey;
    logic             c_bar;
    logic [11:0]      c_w;
    logic             out_valid;
    logic [23:0]      out_rgb;

    ovl_compositor u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_rgb(in_rgb), .in_alpha(in_alpha),
        .cfg_bg(c_bg), .cfg_en(c_en), .cfg_zord(c_z), .cfg_gmode(c_gm),
        .cfg_pmode(c_pm), .cfg_galpha(c_ga), .cfg_sk_en(c_sk),
        .cfg_skey(c_skey), .cfg_dk_en(c_dk), .cfg_dkey(c_dkey),
        .cfg_bar_en(c_bar), .cfg_bar_width(c_w),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    // model shadow state
    logic [23:0]      m_bg;
    logic [1:0]       m_en, m_gm, m_pm, m_sk, m_dk;
    logic [1:0][1:0]  m_z;
    logic [1:0][7:0]  m_ga;
    logic [1:0][23:0] m_skey, m_dkey;
    logic             m_bar;
    logic [11:0]      m_w;
    int               m_col;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    logic [23:0] pal0, pal1;
    bit    qv[$];
    logic [23:0] qr[$];

    function automatic int alpha_of(int i);
        int ga, pa;
        ga = m_ga[i]; pa = in_alpha[i];
        if (!m_en[i]) return 0;
        if (m_sk[i] && in_rgb[i] == m_skey[i]) return 0;
        if (m_gm[i] && m_pm[i]) return (ga * pa + 127) / 255;
        if (m_gm[i]) return ga;
        if (m_pm[i]) return pa;
        return 255;
    endfunction

    function automatic logic [23:0] mix(logic [23:0] t, logic [23:0] b, int a);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            int tv, bv;
            tv = t[c*8 +: 8]; bv = b[c*8 +: 8];
            r[c*8 +: 8] = 8'((a * tv + (255 - a) * bv + 127) / 255);
        end
        return r;
    endfunction

    function automatic logic [23:0] bar_color(int x);
        int idx;
        if (x >= int'(m_w)) idx = 7; else idx = (x * 8) / int'(m_w);
        case (idx)
            0: return 24'hFFFFFF;  1: return 24'hFFFF00;
            2: return 24'h00FFFF;  3: return 24'h00FF00;
            4: return 24'hFF00FF;  5: return 24'hFF0000;
            6: return 24'h0000FF;  default: return 24'h000000;
        endcase
    endfunction

    task automatic model_step();
        int x, order[2], a;
        logic [23:0] plane;
        x = in_sol ? 0 : m_col;
        if (m_bar) plane = bar_color(x);
        else begin
            if (m_z[1] >= m_z[0]) begin order[0] = 0; order[1] = 1; end
            else begin order[0] = 1; order[1] = 0; end
            plane = m_bg;
            foreach (order[k]) begin
                a = alpha_of(order[k]);
                if (m_dk[order[k]] && plane != m_dkey[order[k]]) a = 0;
                plane = mix(in_rgb[order[k]], plane, a);
            end
        end
        qv.push_back(in_valid);
        qr.push_back(plane);
        if (in_valid) m_col = x + 1; else if (in_sol) m_col = 0;
        if (in_sof) begin
            m_bg = c_bg; m_en = c_en; m_gm = c_gm; m_pm = c_pm; m_sk = c_sk;
            m_dk = c_dk; m_z = c_z; m_ga = c_ga; m_skey = c_skey;
            m_dkey = c_dkey; m_bar = c_bar; m_w = c_w;
        end
    endtask

    task automatic compare();
        bit ev = 1'b0;
        logic [23:0] er = '0;
        if (qv.size() == 3) begin ev = qv.pop_front(); er = qr.pop_front(); end
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL %s/R2 valid: got %0b exp %0b", cur_req, out_valid, ev);
        end
        if (ev) begin
            checks++;
            if (out_rgb !== er) begin
                errors++;
                $display("FAIL %s pixel: got %06h exp %06h", cur_req, out_rgb, er);
            end
        end
    endtask

    function automatic logic [23:0] pick(logic [23:0] key);
        if ($urandom % 3 == 0) return key;
        return 24'($urandom);
    endfunction

    function automatic logic [7:0] pick_a();
        case ($urandom % 4)
            0: return 8'd0;
            1: return 8'd255;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic px(input bit v, input bit sol, input bit sof);
        in_valid = v; in_sol = sol; in_sof = sof;
        in_rgb[0] = pick(pal0); in_rgb[1] = pick(pal1);
        in_alpha[0] = pick_a(); in_alpha[1] = pick_a();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input string req);
        cur_req = req;
        for (int i = 0; i < n; i++) px(($urandom % 5) != 0, 1'b0, 1'b0);
    endtask

    task automatic frame();
        px(1'b0, 1'b0, 1'b1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL R2 watchdog: got hang exp completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 0; in_sof = 0; in_sol = 0; in_rgb = '0; in_alpha = '0;
        c_bg = '0; c_en = '0; c_gm = '0; c_pm = '0; c_sk = '0; c_dk = '0; c_z = '0;
        c_ga = '0; c_skey = '0; c_dkey = '0; c_bar = 0; c_w = 12'd16;
        m_bg = '0; m_en = '0; m_gm = '0; m_pm = '0; m_sk = '0; m_dk = '0; m_z = '0;
        m_ga = '0; m_skey = '0; m_dkey = '0; m_bar = 0; m_w = '0; m_col = 0;
        pal0 = 24'h112233; pal1 = 24'h445566;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 valid: got %0b exp 0", out_valid); end
        checks++;
        if (out_rgb !== 24'h0) begin errors++; $display("FAIL R1 rgb: got %06h exp 000000", out_rgb); end
        rst_n = 1'b1;
        run(6, "R1");

        // R4: background only
        c_bg = 24'h123456;
        frame(); run(20, "R4");

        // R5: global alpha on layer 0
        c_en = 2'b01; c_gm = 2'b01; c_ga[0] = 8'd128;
        frame(); run(25, "R5");
        c_ga[0] = 8'd255; frame(); run(10, "R5");
        c_ga[0] = 8'd0;   frame(); run(10, "R5");
        // R6: alpha source combinations
        c_gm = 2'b00; c_pm = 2'b01; frame(); run(20, "R6");
        c_gm = 2'b01; c_pm = 2'b01; c_ga[0] = 8'd77; frame(); run(20, "R6");
        c_gm = 2'b00; c_pm = 2'b00; frame(); run(10, "R6");

        // R7: stacking order
        c_en = 2'b11; c_z[0] = 2'd2; c_z[1] = 2'd1;
        frame(); run(15, "R7");
        c_z[0] = 2'd1; frame(); run(15, "R7");
        c_z[0] = 2'd3; c_z[1] = 2'd0; c_gm = 2'b10; c_ga[1] = 8'd200; frame(); run(15, "R7");
        c_en = 2'b10; c_pm = 2'b11; frame(); run(15, "R7");

        // R8: source key on top layer 1
        c_en = 2'b11; c_z = '0; c_gm = 2'b00; c_pm = 2'b10;
        c_sk = 2'b10; c_skey[1] = 24'h00FF00; pal1 = 24'h00FF00;
        frame(); run(30, "R8");
        c_sk = 2'b01; c_skey[0] = 24'h112233; pal0 = 24'h112233; c_pm = 2'b00;
        frame(); run(20, "R8");

        // R9: destination key
        c_sk = '0; c_dk = 2'b10; c_dkey[1] = 24'hABCDEF; pal0 = 24'hABCDEF;
        frame(); run(30, "R9");
        c_dk = 2'b01; c_dkey[0] = 24'h123456; c_en = 2'b01; frame(); run(15, "R9");
        c_dkey[0] = 24'h654321; frame(); run(15, "R9");
        c_pm = 2'b11; c_dk = 2'b11; c_en = 2'b11; frame(); run(20, "R9");

        // R3: changes without frame start are ignored
        c_dk = '0; c_pm = '0; c_en = 2'b00; frame(); run(5, "R3");
        c_bg = 24'hFEDCBA; c_en = 2'b11; c_bar = 1'b1; run(20, "R3");
        c_bar = 1'b0; frame(); run(10, "R3");

        // R10: color bars
        c_bar = 1'b1; c_w = 12'd16; frame();
        cur_req = "R10";
        px(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 19; i++) px(i != 5, 1'b0, 1'b0);
        px(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) px(1'b1, 1'b0, 1'b0);
        c_w = 12'd40; frame();
        px(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 45; i++) px(1'b1, 1'b0, 1'b0);
        px(1'b1, 1'b1, 1'b0);
        run(10, "R10");
        c_bar = 1'b0; frame(); run(15, "R10");

        for (int i = 0; i < 4; i++) px(1'b0, 1'b0, 1'b0);
        summary();
        $finish;
    end
endmodule